// File: doc/BRIEF.md
# Three-Lane Sum-of-Absolute-Differences Cost Array

This block scores up to three candidate positions of a block-matching motion search in parallel. A single stream of current-block pixels is broadcast to three identical lanes. Each lane also receives its own stream of reference pixels, taken from its own candidate position. Each lane accumulates the absolute difference between its reference pixel and the shared current pixel over one 16x16 block, which is 256 samples. The result is the lane's matching cost. The constant 1/256 scale that would turn this sum into a mean is left out.

A batch is started with a single-cycle start pulse, which also latches a per-lane enable mask. Over the next 256 cycles, one pixel set is consumed per cycle. A one-cycle valid pulse then marks the costs as ready. A search phase that tests only one or two points leaves the other lanes disabled. A disabled lane reports the largest cost value, so it never wins a minimum selection. A new batch may start on the valid cycle itself, so batches can run back to back.

Top module: `sad_cost_array`

## Requirements
- R1: After reset, valid_o and busy_o are 0 and every lane's cost reads 16'hFFFF.
- R2: A start pulse while idle makes busy_o high from the next cycle for exactly 256 cycles. Each of those cycles consumes one sample. valid_o is high for exactly one cycle, the one that follows the last sample, and busy_o is low in that cycle.
- R3: For an enabled lane, the cost equals the sum of |ref - cur| over the 256 sampled cycles. It is cleared when the batch starts.
- R4: Lane k takes its reference pixel from ref_px_i[8k+7:8k]. All lanes use the same cur_px_i. Pixels are 8-bit unsigned.
- R5: A lane whose enable bit was 0 at start reports 16'hFFFF for the whole batch and after it.
- R6: A start pulse while busy_o is high is ignored. The running batch keeps its count and its costs.
- R7: The 16-bit cost holds the worst case, 256 x 255 = 65280, without wrapping.
- R8: A start on the cycle where valid_o is high is accepted, and busy_o is high in the next cycle.
- R9: Between valid_o and the next accepted start, costs hold their values whatever the pixel inputs do.
- R10: The enable mask is sampled only when a start is accepted. Changes to lane_en_i during a batch have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a 256-sample batch (accepted when idle) |
| lane_en_i | input | 3 | Per-lane enable, sampled at start |
| cur_px_i | input | 8 | Current-block pixel, shared by all lanes |
| ref_px_i | input | 24 | Reference pixels, lane k in bits 8k+7:8k |
| cost_o | output | 48 | Lane costs, lane k in bits 16k+15:16k |
| valid_o | output | 1 | One-cycle pulse: costs of the batch are ready |
| busy_o | output | 1 | A batch is consuming samples |

## Verification
The bench builds the block with its default parameters: three lanes, 8-bit pixels and a 256-sample block. With these values the full-scale sum of 65280 sits just under the 16-bit ceiling, so the exact worst case can be checked against wrapping. The real block length also makes the counter's terminal count and the back-to-back restart on the valid cycle visible. The bench exercises masks with single and multiple lanes, start pulses and enable changes in the middle of a batch, and pixel patterns that give each lane a distinct sum.

// File: rtl/sad_cost_pkg.sv
package sad_cost_pkg;

    localparam int DEF_LANES   = 3;
    localparam int DEF_PIX_W   = 8;
    localparam int DEF_BLK_PIX = 256;

    typedef enum logic [0:0] {
        CT_IDLE = 1'b0,
        CT_RUN  = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic clear;
        logic sample;
    } lane_cmd_t;

endpackage

// File: rtl/sad_cost_ctrl.sv
module sad_cost_ctrl
    import sad_cost_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int BLK_PIX = DEF_BLK_PIX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LANES-1:0] lane_en_i,
    output lane_cmd_t        cmd_o,
    output logic [LANES-1:0] mask_o,
    output logic             valid_o,
    output logic             busy_o
);
    localparam int CNT_W = $clog2(BLK_PIX);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_PIX - 1);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LANES-1:0] mask_q;
    logic             valid_q;
    logic             accept;

    assign accept = start_i && (state_q == CT_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CT_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                CT_IDLE: if (accept) begin
                    state_q <= CT_RUN;
                    cnt_q   <= '0;
                    mask_q  <= lane_en_i;
                end
                CT_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= CT_IDLE;
                        valid_q <= 1'b1;
                    end
                end
                default: state_q <= CT_IDLE;
            endcase
        end
    end

    assign cmd_o.clear  = accept;
    assign cmd_o.sample = (state_q == CT_RUN);
    assign mask_o       = mask_q;
    assign valid_o      = valid_q;
    assign busy_o       = (state_q == CT_RUN);

    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    p_enter_run_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == CT_IDLE) |=> (state_q == CT_RUN && cnt_q == '0));
    p_valid_after_run_r2: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (state_q == CT_IDLE && $past(state_q) == CT_RUN));
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CT_RUN && cnt_q != LAST) |=>
            (state_q == CT_RUN && cnt_q == $past(cnt_q) + 1'b1));
    p_mask_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == CT_RUN) |=> $stable(mask_q));

endmodule

// File: rtl/sad_cost_lane.sv
module sad_cost_lane
    import sad_cost_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int COST_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_cmd_t         cmd_i,
    input  logic              en_i,
    input  logic [PIX_W-1:0]  cur_i,
    input  logic [PIX_W-1:0]  ref_i,
    output logic [COST_W-1:0] cost_o
);
    logic [PIX_W-1:0]  diff;
    logic [COST_W-1:0] acc_q;

    always_comb begin
        if (ref_i > cur_i) diff = ref_i - cur_i;
        else               diff = cur_i - ref_i;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clear) begin
            acc_q <= '0;
        end else if (cmd_i.sample && en_i) begin
            acc_q <= acc_q + COST_W'(diff);
        end
    end

    assign cost_o = en_i ? acc_q : '1;

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.sample && en_i && !cmd_i.clear) |=> (acc_q >= $past(acc_q)));
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (acc_q == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.sample && !cmd_i.clear) |=> $stable(acc_q));

endmodule

// File: rtl/sad_cost_array.sv
module sad_cost_array
    import sad_cost_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int PIX_W   = DEF_PIX_W,
    parameter int BLK_PIX = DEF_BLK_PIX,
    localparam int COST_W = PIX_W + $clog2(BLK_PIX)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [LANES-1:0]        lane_en_i,
    input  logic [PIX_W-1:0]        cur_px_i,
    input  logic [LANES*PIX_W-1:0]  ref_px_i,
    output logic [LANES*COST_W-1:0] cost_o,
    output logic                    valid_o,
    output logic                    busy_o
);
    lane_cmd_t        cmd;
    logic [LANES-1:0] mask;

    sad_cost_ctrl #(.LANES(LANES), .BLK_PIX(BLK_PIX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .lane_en_i (lane_en_i),
        .cmd_o     (cmd),
        .mask_o    (mask),
        .valid_o   (valid_o),
        .busy_o    (busy_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sad_cost_lane #(.PIX_W(PIX_W), .COST_W(COST_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .cmd_i  (cmd),
            .en_i   (mask[k]),
            .cur_i  (cur_px_i),
            .ref_i  (ref_px_i[k*PIX_W +: PIX_W]),
            .cost_o (cost_o[k*COST_W +: COST_W])
        );
    end

endmodule

// File: tb/sim_sad_cost_array.sv
module sim_sad_cost_array;
    localparam int CLK_NS = 10;
    localparam int NL     = 3;
    localparam int PW     = 8;
    localparam int BLK    = 256;
    localparam int CW     = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NL-1:0]   en = '0;
    logic [PW-1:0]   cur = '0;
    logic [NL*PW-1:0] refp = '0;
    logic [NL*CW-1:0] cost;
    logic            valid;
    logic            busy;

    int errors = 0;
    int checks = 0;

    // behavioural reference model state
    int m_busy = 0, m_cnt = 0, m_valid = 0;
    int m_acc [NL];
    int m_en  [NL];

    always #(CLK_NS/2) clk = ~clk;

    sad_cost_array u0 (
        .clk(clk), .rst(rst), .start_i(start), .lane_en_i(en),
        .cur_px_i(cur), .ref_px_i(refp),
        .cost_o(cost), .valid_o(valid), .busy_o(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lane_cost(input int k);
        return int'(cost[k*CW +: CW]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_valid = 0;
            for (int k = 0; k < NL; k++) begin m_acc[k] = 0; m_en[k] = 0; end
        end else begin
            m_valid = 0;
            if (m_busy != 0) begin
                for (int k = 0; k < NL; k++) begin
                    int r;
                    r = int'(refp[k*PW +: PW]);
                    if (m_en[k] != 0) m_acc[k] += (r > int'(cur)) ? r - int'(cur) : int'(cur) - r;
                end
                m_cnt++;
                if (m_cnt == BLK) begin m_busy = 0; m_valid = 1; end
            end else if (start) begin
                m_busy = 1; m_cnt = 0;
                for (int k = 0; k < NL; k++) begin m_en[k] = int'(en[k]); m_acc[k] = 0; end
            end
        end
    end

    // per-clock comparison against the model (R2, R3, R5)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 valid", int'(valid), m_valid);
            chk("R2 busy", int'(busy), m_busy);
            for (int k = 0; k < NL; k++) begin
                if (m_en[k] != 0) chk("R3 cost", lane_cost(k), m_acc[k]);
                else              chk("R5 cost", lane_cost(k), 65535);
            end
        end
    end

    function automatic logic [PW-1:0] ref_pat(input int pat, input int i, input int k);
        case (pat)
            0:       return PW'((i*7 + k*31 + ((k == 1) ? i*i : 0)) & 255);
            1:       return PW'(255);
            default: return PW'(k*40);
        endcase
    endfunction

    function automatic logic [PW-1:0] cur_pat(input int pat, input int i);
        case (pat)
            0:       return PW'((i*13) & 255);
            1:       return PW'(0);
            default: return PW'(255);
        endcase
    endfunction

    // starts at the current negedge; returns at the negedge where valid shows
    task automatic batch(input logic [NL-1:0] mask, input int pat,
                         input bit mid_start, input bit en_toggle);
        start = 1'b1;
        en    = mask;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", int'(busy), 1);
        for (int i = 0; i < BLK; i++) begin
            cur = cur_pat(pat, i);
            for (int k = 0; k < NL; k++) refp[k*PW +: PW] = ref_pat(pat, i, k);
            if (mid_start && i == 100) start = 1'b1;
            if (mid_start && i == 101) start = 1'b0;
            if (en_toggle && i == 50) en = ~en;
            @(negedge clk);
        end
        chk("R2 valid at end", int'(valid), 1);
        chk("R2 busy low at valid", int'(busy), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 valid", int'(valid), 0);
        chk("R1 busy", int'(busy), 0);
        for (int k = 0; k < NL; k++) chk("R1 cost", lane_cost(k), 65535);
        @(negedge clk);

        batch(3'b111, 0, 1'b0, 1'b0);
        chk("R3 lane0 matches model", lane_cost(0), m_acc[0]);

        batch(3'b111, 1, 1'b0, 1'b0);           // R8 back to back, R7 worst case
        for (int k = 0; k < NL; k++) chk("R7 full scale", lane_cost(k), 65280);

        batch(3'b010, 2, 1'b1, 1'b1);           // R6 mid start, R10 enable change
        chk("R5 lane0 disabled", lane_cost(0), 65535);
        chk("R5 lane2 disabled", lane_cost(2), 65535);
        chk("R6 R10 lane1", lane_cost(1), 256*(255-40));

        @(negedge clk);
        batch(3'b111, 2, 1'b0, 1'b0);           // R4 distinct lane sums
        for (int k = 0; k < NL; k++) chk("R4 lane sum", lane_cost(k), 256*(255-40*k));

        for (int j = 0; j < 6; j++) begin       // R9 hold while idle
            cur  = PW'(j*37);
            refp = 24'(j*12345);
            @(negedge clk);
        end
        for (int k = 0; k < NL; k++) chk("R9 hold", lane_cost(k), 256*(255-40*k));
        chk("R9 idle", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule